// File: doc/BRIEF.md
# Multi-Level Priority Interrupt Arbiter

This block sits beside the processor core and arbitrates among a set of interrupt sources. Each source has its own request line and its own acknowledge line. Line index i carries level i+1, and level 0 stands for ordinary program execution. The block keeps a processor-status word with two fields: a level field that records the current processor priority, and a global enable bit. A request is taken only when the global enable bit is set and the request's level is strictly higher than the current level.

When a request is taken, the block does four things. It acknowledges that source, saves the old level and enable bit on a nesting stack, raises the current level to the source's level, and clears the enable bit. A return-from-service input pops the stack and restores both fields. Software can rewrite both fields through a status-write port, but only in supervisor mode. A write attempted in user mode is refused and raises a one-cycle privileged-exception pulse.

Top module: `prio_irq_arb`

## Requirements
- R1: After reset, the current level is 0, the enable bit is 0, all acknowledges are low, and the exception and overflow outputs are low.
- R2: A request on line i (level i+1) is taken only when the enable bit is 1 and i+1 is greater than the current level. Any other request has no effect on the level or the acknowledges.
- R3: When several requests are eligible in the same cycle, the one on the highest line index is taken.
- R4: The acknowledge of the taken line is high for exactly the one cycle after the clock edge at which the request was taken. No other acknowledge bit is high at that time.
- R5: On taking line i, the current level becomes i+1, the enable bit becomes 0, and the previous {level, enable} pair is pushed onto the nesting stack.
- R6: A return-from-service pulse pops the stack and restores the saved level and enable bit. A return issued when the stack is empty leaves both fields unchanged.
- R7: A status write in supervisor mode loads both the level field and the enable bit. The new values are visible after the next clock edge.
- R8: A status write in user mode leaves the level and the enable bit unchanged. It raises the exception output for exactly one cycle after that edge.
- R9: The stack holds 8 entries. A push onto a full stack discards the entry and sets an overflow flag that stays set until reset.
- R10: When events arrive in the same cycle, a return takes precedence over a status write, and a status write takes precedence over taking a request. A lower-precedence event in that cycle is dropped without effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Per-source interrupt requests; bit i has level i+1 |
| ack_o | output | 8 | Per-source acknowledge pulses |
| reti_i | input | 1 | Return-from-service pulse; pops the nesting stack |
| ps_wr_i | input | 1 | Status-word write strobe |
| ps_lvl_i | input | 4 | Level value to write |
| ps_ie_i | input | 1 | Enable bit value to write |
| sup_mode_i | input | 1 | High while the processor is in supervisor mode |
| cur_lvl_o | output | 4 | Current processor priority level |
| ie_o | output | 1 | Global interrupt-enable bit |
| priv_exc_o | output | 1 | One-cycle pulse on a refused user-mode status write |
| stk_ovf_o | output | 1 | Sticky nesting-stack overflow flag |

## Verification
The assertions assume that a return pulse never arrives while the stack is empty in a way that would pop it. The top gates the pop with the empty flag, so that assumption holds inside the block no matter what the environment drives. They also assume that requests stay stable for one cycle around an edge, and the stimulus meets this by changing inputs only on the falling clock edge. The stimulus covers every pairing of a level from 0 to 8 with every single request line, all 255 non-empty request masks, a nesting run that fills the stack and overflows it once, and same-cycle collisions of return, write and request.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RET  = 2'd1,
    OP_WR   = 2'd2,
    OP_TAKE = 2'd3
  } arb_op_e;
endpackage

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int N_SRC = 8,
  parameter int LVL_W = $clog2(N_SRC + 1),
  parameter int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             ie_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [LVL_W-1:0] lvl_o
);
  logic [N_SRC-1:0] elig;

  for (genvar g = 0; g < N_SRC; g++) begin : g_elig
    assign elig[g] = req_i[g] && ie_i && (LVL_W'(g + 1) > cur_lvl_i);
  end

  // ascending scan, last hit wins -> highest level
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end

  assign lvl_o = LVL_W'(idx_o) + LVL_W'(1);
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 5,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         ovf_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] top_idx;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign top_o   = mem[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else if (push_i) begin
      if (full_o) ovf_o <= 1'b1;
      else        cnt_q <= cnt_q + CNT_W'(1);
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem[IDX_W'(cnt_q)] <= din_i;
  end

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R9
  AST_FULL_PUSH_OVF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |=> (ovf_o && full_o)); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R6
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
#(
  parameter int N_SRC     = 8,
  parameter int STK_DEPTH = 8,
  parameter int LVL_W     = $clog2(N_SRC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  output logic [N_SRC-1:0] ack_o,
  input  logic             reti_i,
  input  logic             ps_wr_i,
  input  logic [LVL_W-1:0] ps_lvl_i,
  input  logic             ps_ie_i,
  input  logic             sup_mode_i,
  output logic [LVL_W-1:0] cur_lvl_o,
  output logic             ie_o,
  output logic             priv_exc_o,
  output logic             stk_ovf_o
);
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int ENT_W = LVL_W + 1;

  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic [LVL_W-1:0] pick_lvl;
  logic [ENT_W-1:0] stk_top;
  logic             stk_empty, stk_full;
  logic             push, pop;
  arb_op_e          op;

  prio_irq_pick #(.N_SRC(N_SRC), .LVL_W(LVL_W), .IDX_W(IDX_W)) u_pick (
    .req_i     (req_i),
    .cur_lvl_i (cur_lvl_o),
    .ie_i      (ie_o),
    .vld_o     (pick_vld),
    .idx_o     (pick_idx),
    .lvl_o     (pick_lvl)
  );

  always_comb begin
    if (reti_i)        op = OP_RET;
    else if (ps_wr_i)  op = OP_WR;
    else if (pick_vld) op = OP_TAKE;
    else               op = OP_IDLE;
  end

  assign push = (op == OP_TAKE);
  assign pop  = (op == OP_RET) && !stk_empty;

  prio_irq_stack #(.DEPTH(STK_DEPTH), .W(ENT_W)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .pop_i   (pop),
    .din_i   ({cur_lvl_o, ie_o}),
    .top_o   (stk_top),
    .empty_o (stk_empty),
    .full_o  (stk_full),
    .ovf_o   (stk_ovf_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_lvl_o  <= '0;
      ie_o       <= 1'b0;
      ack_o      <= '0;
      priv_exc_o <= 1'b0;
    end else begin
      ack_o      <= '0;
      priv_exc_o <= 1'b0;
      case (op)
        OP_RET: if (!stk_empty) {cur_lvl_o, ie_o} <= stk_top;
        OP_WR: begin
          if (sup_mode_i) begin
            cur_lvl_o <= ps_lvl_i;
            ie_o      <= ps_ie_i;
          end else begin
            priv_exc_o <= 1'b1;
          end
        end
        OP_TAKE: begin
          cur_lvl_o <= pick_lvl;
          ie_o      <= 1'b0;
          ack_o     <= N_SRC'(1) << pick_idx;
        end
        default: ;
      endcase
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o)); // R4
  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o != '0) |=> (ack_o == '0)); // R4
  AST_TAKE_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_TAKE) |=> (cur_lvl_o > $past(cur_lvl_o) && !ie_o && ack_o != '0)); // R5
  AST_NO_TAKE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_o |-> !pick_vld); // R2
  AST_USER_WR_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_WR && !sup_mode_i) |=> ($stable(cur_lvl_o) && $stable(ie_o) && priv_exc_o)); // R8
  AST_EXC_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_exc_o |=> !priv_exc_o || $past(ps_wr_i && !sup_mode_i && !reti_i)); // R8
endmodule

// File: tb/prio_irq_arb_tb.sv
module prio_irq_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req = '0;
  logic [7:0] ack;
  logic       reti = 1'b0, ps_wr = 1'b0, ps_ie = 1'b0, sup = 1'b1;
  logic [3:0] ps_lvl = '0;
  logic [3:0] cur_lvl;
  logic       ie, priv_exc, ovf;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .ack_o(ack), .reti_i(reti),
    .ps_wr_i(ps_wr), .ps_lvl_i(ps_lvl), .ps_ie_i(ps_ie), .sup_mode_i(sup),
    .cur_lvl_o(cur_lvl), .ie_o(ie), .priv_exc_o(priv_exc), .stk_ovf_o(ovf)
  );

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    req = '0; reti = 1'b0; ps_wr = 1'b0; sup = 1'b1;
    step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic wr(input int lvl, input bit en);
    ps_wr = 1'b1; sup = 1'b1; ps_lvl = 4'(lvl); ps_ie = en;
    step();
    ps_wr = 1'b0;
  endtask

  task automatic ret();
    reti = 1'b1;
    step();
    reti = 1'b0;
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 lvl", cur_lvl, 0);
    chk("R1 ie", ie, 0);
    chk("R1 ack", ack, 0);
    chk("R1 exc", priv_exc, 0);
    chk("R1 ovf", ovf, 0);

    // R2 disabled: no request taken
    for (int i = 0; i < 8; i++) begin
      req = 8'(1 << i);
      step();
      chk("R2 masked ack", ack, 0);
      chk("R2 masked lvl", cur_lvl, 0);
    end
    req = '0;

    // R2/R4/R5/R6/R7 sweep of level x line
    for (int l = 0; l <= 8; l++) begin
      for (int i = 0; i < 8; i++) begin
        wr(l, 1'b1);
        chk("R7 lvl", cur_lvl, l);
        chk("R7 ie", ie, 1);
        req = 8'(1 << i);
        step();
        req = '0;
        if (i + 1 > l) begin
          chk("R4 ack", ack, 1 << i);
          chk("R5 lvl", cur_lvl, i + 1);
          chk("R5 ie", ie, 0);
          step();
          chk("R4 ack drop", ack, 0);
          ret();
          chk("R6 lvl", cur_lvl, l);
          chk("R6 ie", ie, 1);
        end else begin
          chk("R2 ack", ack, 0);
          chk("R2 lvl", cur_lvl, l);
        end
      end
    end

    // R3 every nonzero mask at level 0
    for (int m = 1; m < 256; m++) begin
      int hi = 0;
      for (int b = 0; b < 8; b++) if (m[b]) hi = b;
      wr(0, 1'b1);
      req = 8'(m);
      step();
      req = '0;
      chk("R3 ack", ack, 1 << hi);
      chk("R3 lvl", cur_lvl, hi + 1);
      ret();
    end

    // R9 nesting fills stack then overflows
    do_reset();
    wr(0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      req = 8'(1 << k);
      step();
      req = '0;
      chk("R5 nest lvl", cur_lvl, k + 1);
      chk("R4 nest ack", ack, 1 << k);
      wr(k + 1, 1'b1);
    end
    chk("R9 no ovf", ovf, 0);
    wr(0, 1'b1);
    req = 8'h04;
    step();
    req = '0;
    chk("R9 ovf push lvl", cur_lvl, 3);
    chk("R9 ovf set", ovf, 1);
    for (int k = 7; k >= 0; k--) begin
      ret();
      chk("R6 pop lvl", cur_lvl, k);
      chk("R6 pop ie", ie, 1);
    end
    ret();
    chk("R6 empty lvl", cur_lvl, 0);
    chk("R6 empty ie", ie, 1);
    chk("R9 ovf sticky", ovf, 1);

    // R8 user-mode write refused
    do_reset();
    wr(2, 1'b1);
    ps_wr = 1'b1; sup = 1'b0; ps_lvl = 4'd5; ps_ie = 1'b0;
    step();
    ps_wr = 1'b0; sup = 1'b1;
    chk("R8 lvl", cur_lvl, 2);
    chk("R8 ie", ie, 1);
    chk("R8 exc", priv_exc, 1);
    step();
    chk("R8 exc pulse", priv_exc, 0);

    // R10 precedence
    wr(0, 1'b1);
    req = 8'h20;
    step();
    req = '0;
    chk("R10 setup lvl", cur_lvl, 6);
    reti = 1'b1; ps_wr = 1'b1; ps_lvl = 4'd2; ps_ie = 1'b0; req = 8'h80;
    step();
    reti = 1'b0; ps_wr = 1'b0; req = '0;
    chk("R10 ret wins lvl", cur_lvl, 0);
    chk("R10 ret wins ie", ie, 1);
    chk("R10 ret no ack", ack, 0);
    ps_wr = 1'b1; ps_lvl = 4'd3; ps_ie = 1'b1; req = 8'h80;
    step();
    ps_wr = 1'b0;
    chk("R10 wr wins lvl", cur_lvl, 3);
    chk("R10 wr no ack", ack, 0);
    step();
    req = '0;
    chk("R10 later take", cur_lvl, 8);
    chk("R10 later ack", ack, 8'h80);

    step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule